// File: doc/BRIEF.md
# Bottom-Origin Framebuffer Scan Address Generator

This block turns the raster position of a 1024x768 one-bit-per-pixel display into word addresses for a 32-bit-wide memory. Each memory word holds 32 horizontally adjacent pixels, so one visible line needs 32 words and the whole picture needs 98304 bytes. The framebuffer keeps the bottom screen line at its lowest address. The raster, however, scans from the top line down. The block therefore bit-inverts the vertical count before it adds the count to a fixed origin. As a result, memory rows are read in descending order while the display scans downward.

The horizontal and vertical counters come from the pixel-timing logic. The horizontal counter is 11 bits wide because it also runs through the retrace interval; the vertical counter is 10 bits wide. On each edge of the memory clock, the block samples the word-in-line index (horizontal bits [9:5]) and the vertical count. It registers the resulting word address and a fetch strobe. Outside the visible area the fetch strobe is low and the address register keeps its last value.

Top module: `fb_scan_addr`

## Requirements
- R1: While reset is asserted, and on the first memory clock edge after it, `fetch` is 0 and `word_addr` is 0.
- R2: Bits [4:0] of `word_addr` equal horizontal count bits [9:5] sampled at the previous edge. The horizontal direction is not inverted: index 0 is the leftmost 32 pixels.
- R3: After a memory clock edge that samples a visible position (h,v), `word_addr` equals 0x37FC0 + {3'b000, ~v[9:0], h[9:5]}. The value 0x37FC0 is the word address of byte 0xDFF00.
- R4: Raster line 0, word 0 gives word address 0x3FFA0 (byte 0xFFE80). Raster line 767, word 0 gives word address 0x39FC0 (byte 0xE7F00, the framebuffer base).
- R5: When the sampled horizontal count is at or above 1024, or the sampled vertical count is at or above 768, `word_addr` holds its previous value.
- R6: `fetch` is 1 after an edge that samples a visible position, and 0 after an edge that samples a blanked position.
- R7: Every address issued with `fetch` high lies in the frame window 0x39FC0 to 0x3FFBF inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_count | input | 11 | Horizontal raster counter, including retrace |
| v_count | input | 10 | Vertical raster counter |
| word_addr | output | 18 | Registered word address into 32-bit memory |
| fetch | output | 1 | High when `word_addr` was computed from a visible position |

## Verification
The hardest case to reach is a retrace or blanked sample that follows directly after a visible one whose address differs from the reset value. Only that sequence shows whether the address is really held and not recomputed or cleared. The random stimulus mixes visible and blanked coordinates on every cycle to produce many such transitions. Horizontal values from 1024 to 2047 exercise the case where the word-index bits alone would look valid. Directed steps cover the top line and bottom line, the last visible line and column, and the vertical counts 768 to 1023 that lie above the frame.

// File: rtl/fb_scan_addr.sv
module fb_scan_addr #(
  parameter int H_W      = 11,
  parameter int V_W      = 10,
  parameter int ADDR_W   = 18,
  parameter int H_VIS    = 1024,
  parameter int V_VIS    = 768,
  parameter int PIX_WORD = 32,
  parameter logic [ADDR_W-1:0] ORIGIN = 18'h37FC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [H_W-1:0]    h_count,
  input  logic [V_W-1:0]    v_count,
  output logic [ADDR_W-1:0] word_addr,
  output logic              fetch
);
  localparam int SHIFT = $clog2(PIX_WORD);
  localparam int IDX_W = $clog2(H_VIS) - SHIFT;
  localparam int PAD_W = ADDR_W - V_W - IDX_W;

  logic [IDX_W-1:0]  word_idx;
  logic              visible;
  logic [ADDR_W-1:0] next_addr;

  assign word_idx  = h_count[SHIFT +: IDX_W];
  assign visible   = (h_count < H_W'(H_VIS)) && (v_count < V_W'(V_VIS));
  assign next_addr = ORIGIN + {{PAD_W{1'b0}}, ~v_count, word_idx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_addr <= '0;
      fetch     <= 1'b0;
    end else begin
      fetch <= visible;
      if (visible) word_addr <= next_addr;
    end
  end
endmodule

// File: rtl/fb_scan_addr_chk.sv
module fb_scan_addr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [10:0] h_count,
  input logic [9:0]  v_count,
  input logic [17:0] word_addr,
  input logic        fetch
);
  a_r2_word_index: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> word_addr[4:0] == $past(h_count[9:5]));

  a_r5_hold_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch |-> $stable(word_addr));

  a_r6_fetch_visible: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> ($past(h_count) < 11'd1024 && $past(v_count) < 10'd768));

  a_r7_window: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> (word_addr >= 18'h39FC0 && word_addr <= 18'h3FFBF));

  a_r3_row_order: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> word_addr[17:5] == 13'h1BFE + 13'({3'b000, ~$past(v_count)}));
endmodule

bind fb_scan_addr fb_scan_addr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .h_count(h_count), .v_count(v_count),
  .word_addr(word_addr), .fetch(fetch));

// File: tb/test_fb_scan_addr.sv
module test_fb_scan_addr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] h_count = '0;
  logic [9:0]  v_count = '0;
  logic [17:0] word_addr;
  logic        fetch;

  int checks = 0;
  int errors = 0;
  logic [17:0] exp_addr = '0;
  logic        exp_fetch = 1'b0;

  always #10 clk = ~clk;

  fb_scan_addr i_fb_scan_addr (
    .clk(clk), .rst_n(rst_n), .h_count(h_count), .v_count(v_count),
    .word_addr(word_addr), .fetch(fetch));

  function automatic logic [17:0] ref_addr(input logic [10:0] h, input logic [9:0] v);
    int row;
    row = 1023 - int'(v);
    return 18'(32'h37FC0 + row * 32 + int'(h) / 32 % 32);
  endfunction

  function automatic bit is_vis(input logic [10:0] h, input logic [9:0] v);
    return (h < 11'd1024) && (v < 10'd768);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [10:0] h, input logic [9:0] v, input string req);
    h_count = h;
    v_count = v;
    if (is_vis(h, v)) exp_addr = ref_addr(h, v);
    exp_fetch = is_vis(h, v);
    @(negedge clk);
    check({req, " fetch"}, 32'(fetch), 32'(exp_fetch));
    check({req, " addr"}, 32'(word_addr), 32'(exp_addr));
    if (fetch && (word_addr < 18'h39FC0 || word_addr > 18'h3FFBF))
      check("R7 window", 32'(word_addr), 32'h39FC0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R1 reset fetch", 32'(fetch), 0);
    check("R1 reset addr", 32'(word_addr), 0);
    rst_n = 1'b1;
    step(11'd1500, 10'd5, "R1 first edge");

    step(11'd0, 10'd0, "R4 top line");
    check("R4 top byte", 32'(word_addr) << 2, 32'hFFE80);
    step(11'd0, 10'd767, "R4 bottom line");
    check("R4 base byte", 32'(word_addr) << 2, 32'hE7F00);
    step(11'd1023, 10'd767, "R2 last word");
    check("R2 index", 32'(word_addr[4:0]), 31);
    step(11'd1024, 10'd100, "R5 h retrace");
    step(11'd2047, 10'd100, "R5 h max");
    step(11'd37, 10'd768, "R5 v first blank");
    step(11'd37, 10'd1023, "R5 v max");
    step(11'd37, 10'd767, "R6 back visible");
    for (int x = 0; x < 1100; x += 32) step(11'(x), 10'd300, "R2 line scan");

    for (int i = 0; i < 3000; i++) begin
      logic [10:0] h;
      logic [9:0]  v;
      h = 11'($urandom);
      v = 10'($urandom);
      if ($urandom % 3 != 0) begin
        h = 11'($urandom % 1024);
        v = 10'($urandom % 768);
      end
      step(h, v, "R3 random");
    end

    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset fetch", 32'(fetch), 0);
    check("R1 re-reset addr", 32'(word_addr), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule